// File: doc/BRIEF.md
# Multi-Register Predicated Word Load Sequencer

This block carries out a single contiguous load of 32-bit words into a group of two or four vector registers with adjacent indices. A decoded command supplies a 64-bit base, a signed 4-bit immediate, a group-size bit, a destination field, a base-register selector with a separate stack-pointer value, and an active-element count. The block first forms the start address. It then walks the whole group as one element sequence, one register at a time and in lane order within each register. For each active element it issues one 32-bit read on a valid/ready memory port. Each inactive element has its lane forced to zero and causes no read. After the last lane of a register is filled, the register goes out on a one-cycle writeback strobe.

A scheduler hands over one command when `cmd_ready` is high, then waits for `done` or `align_err` before the next. The vector length is a parameter (default 128 bits, four words per register), and it must be a power of two of at least 64 bits.

The control is a state machine with seven states:
- IDLE: accepts a command. It goes to ERR on a misaligned stack-pointer base and to PICK otherwise.
- PICK: judges the current element. An active element goes to REQ. An inactive one writes a zero lane, then goes to WB after the last lane or stays in PICK.
- REQ: holds the read until it is accepted, then goes to RSP.
- RSP: waits for the response data and stores it. It goes to WB after the last lane and to PICK otherwise.
- WB: emits the register. It goes to DONE after the final register and to PICK otherwise.
- DONE and ERR: each lasts one cycle and then returns to IDLE.

Top module: `vec_multi_load_seq`

## Requirements
- R1: The first address in the element sequence is the selected base plus the sign-extended 4-bit immediate times the register count, times the words per register, times 4. The sum wraps modulo 2^64.
- R2: Element i of the group (i = register number times words per register, plus lane number) sits at the start address plus 4*i, wrapping at 64 bits. The address advances for every element, whether it is read or not.
- R3: An element is active exactly when its overall index i is below `cmd_count`. Exactly one read is issued per active element, none for an inactive one, and reads come in increasing i order.
- R4: In every written-back register, the lane of an active element holds the response data for that element's read. The lane of an inactive element holds zero. Lane k occupies bits 32k+31..32k.
- R5: `cmd_quad` = 0 selects two registers and `cmd_quad` = 1 selects four. Exactly that many writebacks occur, in register order, and a writeback never coincides with a read request.
- R6: The first destination index is `cmd_zt` times 2 in the two-register form. In the four-register form it is the low three bits of `cmd_zt` times 4. Later registers use the following indices, modulo 32.
- R7: When `cmd_rn` equals 31, the base is taken from `cmd_sp` and `cmd_base` is ignored. If `cmd_sp[3:0]` is nonzero, `align_err` pulses in the next cycle, and there are no reads, no writebacks and no `done`. The base from `cmd_base` is never alignment-checked.
- R8: `mem_req_nt` is high in every cycle where `mem_req_valid` is high.
- R9: A read request stays asserted with a stable address until it is accepted. At most one read is outstanding, and the next request appears only after its response.
- R10: `cmd_ready` is high only while idle. It is high after reset and low from the cycle after a command is accepted until completion. `done` is a single-cycle pulse in the cycle right after the final writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken this cycle if offered |
| cmd_base | input | 64 | Base address from a general register |
| cmd_sp | input | 64 | Stack-pointer value, used when cmd_rn is 31 |
| cmd_rn | input | 5 | Base register selector |
| cmd_imm | input | 4 | Signed immediate group offset |
| cmd_quad | input | 1 | 0: two registers, 1: four registers |
| cmd_zt | input | 4 | Destination field |
| cmd_count | input | 5 | Number of leading active elements |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Byte address of the word read |
| mem_req_nt | output | 1 | Non-temporal hint |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| wb_valid | output | 1 | Register writeback strobe |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 128 | Assembled register value |
| done | output | 1 | Command complete pulse |
| align_err | output | 1 | Misaligned stack-pointer base pulse |

## Verification
A wrong lane or register counter first shows at the memory port. A read appears at an address off the start+4*i grid, or a read appears for an index at or above the count. Either is visible on the very next request. A wrong counter can also cost a writeback, so a register index is skipped or an extra register comes out; this shows at the next WB cycle. A lane buffer that keeps stale data, or one that fails to clear inactive lanes, shows only in the writeback data for that register. Every writeback is therefore compared in full with a vector rebuilt from the requirements.

// File: rtl/vlm_pkg.sv
package vlm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_REQ,
        ST_RSP,
        ST_WB,
        ST_DONE,
        ST_ERR
    } vlm_state_e;

    localparam int          ELEM_BITS  = 32;
    localparam int          ELEM_BYTES = ELEM_BITS / 8;
    localparam logic [4:0]  SP_SEL     = 5'd31;
    localparam int          SP_ALIGN_B = 4;

endpackage

// File: rtl/vlm_start_addr.sv
module vlm_start_addr
    import vlm_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int WORDS  = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [3:0]        imm,
    input  logic              quad,
    output logic [ADDR_W-1:0] start
);
    // log2 of the bytes in one register
    localparam int REG_SH = $clog2(WORDS) + $clog2(ELEM_BYTES);

    logic [ADDR_W-1:0] imm_x;
    logic [ADDR_W-1:0] offs;

    always_comb begin
        imm_x = {{(ADDR_W-4){imm[3]}}, imm};
        offs  = quad ? (imm_x << (REG_SH + 2)) : (imm_x << (REG_SH + 1));
        start = base + offs;
    end
endmodule

// File: rtl/vlm_active.sv
module vlm_active #(
    parameter int WORDS = 4,
    parameter int CNT_W = 5
) (
    input  logic [1:0]               reg_i,
    input  logic [$clog2(WORDS)-1:0] elem_i,
    input  logic [CNT_W-1:0]         count,
    output logic                     active
);
    localparam int EW = $clog2(WORDS);

    logic [EW+1:0] idx;

    always_comb begin
        idx    = {reg_i, elem_i};
        active = ({{(CNT_W-EW-2){1'b0}}, idx} < count);
    end
endmodule

// File: rtl/vlm_lane_buf.sv
module vlm_lane_buf #(
    parameter int WORDS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(WORDS)-1:0] wr_lane,
    input  logic [31:0]              wr_data,
    output logic [32*WORDS-1:0]      vec
);
    localparam int EW = $clog2(WORDS);

    logic [31:0] lane_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
            end else if (wr_en && (wr_lane == EW'(g))) begin
                lane_q[g] <= wr_data;
            end
        end
        assign vec[32*g +: 32] = lane_q[g];
    end
endmodule

// File: rtl/vec_multi_load_seq.sv
module vec_multi_load_seq
    import vlm_pkg::*;
#(
    parameter  int VLEN   = 128,
    parameter  int ADDR_W = 64,
    parameter  int IDX_W  = 5,
    localparam int WORDS  = VLEN / ELEM_BITS,
    localparam int CNT_W  = $clog2(4 * WORDS + 1),
    localparam int ZT_W   = IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [ADDR_W-1:0] cmd_sp,
    input  logic [4:0]        cmd_rn,
    input  logic [3:0]        cmd_imm,
    input  logic              cmd_quad,
    input  logic [ZT_W-1:0]   cmd_zt,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_nt,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [VLEN-1:0]   wb_data,
    output logic              done,
    output logic              align_err
);
    localparam int EW = $clog2(WORDS);

    vlm_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        reg_q;
    logic [EW-1:0]     elem_q;
    logic              quad_q;
    logic [ZT_W-1:0]   zt_q;
    logic [CNT_W-1:0]  count_q;

    logic [ADDR_W-1:0] sel_base;
    logic [ADDR_W-1:0] start_addr;
    logic              use_sp;
    logic              sp_bad;
    logic              elem_active;
    logic              last_elem;
    logic              last_reg;
    logic              advance;
    logic              lane_we;
    logic [31:0]       lane_wd;
    logic [IDX_W-1:0]  first_idx;

    // ---------------------------------------------------------------
    // Command-side decode
    // ---------------------------------------------------------------
    always_comb begin
        use_sp   = (cmd_rn == SP_SEL);
        sel_base = use_sp ? cmd_sp : cmd_base;
        sp_bad   = use_sp && (cmd_sp[SP_ALIGN_B-1:0] != '0);
    end

    vlm_start_addr #(
        .ADDR_W (ADDR_W),
        .WORDS  (WORDS)
    ) u_start (
        .base  (sel_base),
        .imm   (cmd_imm),
        .quad  (cmd_quad),
        .start (start_addr)
    );

    vlm_active #(
        .WORDS (WORDS),
        .CNT_W (CNT_W)
    ) u_active (
        .reg_i  (reg_q),
        .elem_i (elem_q),
        .count  (count_q),
        .active (elem_active)
    );

    always_comb begin
        last_elem = (elem_q == EW'(WORDS - 1));
        last_reg  = quad_q ? (reg_q == 2'd3) : (reg_q == 2'd1);
        advance   = ((state_q == ST_PICK) && !elem_active) ||
                    ((state_q == ST_RSP) && mem_rsp_valid);
        lane_we   = advance;
        lane_wd   = (state_q == ST_RSP) ? mem_rsp_data : 32'd0;
        first_idx = quad_q ? {zt_q[ZT_W-2:0], 2'b00} : {zt_q, 1'b0};
    end

    vlm_lane_buf #(
        .WORDS (WORDS)
    ) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lane_we),
        .wr_lane (elem_q),
        .wr_data (lane_wd),
        .vec     (wb_data)
    );

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    state_d = sp_bad ? ST_ERR : ST_PICK;
                end
            end
            ST_PICK: begin
                if (elem_active) begin
                    state_d = ST_REQ;
                end else if (last_elem) begin
                    state_d = ST_WB;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    state_d = ST_RSP;
                end
            end
            ST_RSP: begin
                if (mem_rsp_valid) begin
                    state_d = last_elem ? ST_WB : ST_PICK;
                end
            end
            ST_WB:   state_d = last_reg ? ST_DONE : ST_PICK;
            ST_DONE: state_d = ST_IDLE;
            ST_ERR:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------
    // Walk counters and latched command
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            reg_q   <= '0;
            elem_q  <= '0;
            quad_q  <= 1'b0;
            zt_q    <= '0;
            count_q <= '0;
        end else if ((state_q == ST_IDLE) && cmd_valid) begin
            addr_q  <= start_addr;
            reg_q   <= '0;
            elem_q  <= '0;
            quad_q  <= cmd_quad;
            zt_q    <= cmd_zt;
            count_q <= cmd_count;
        end else if (advance) begin
            addr_q  <= addr_q + ADDR_W'(ELEM_BYTES);
            elem_q  <= elem_q + 1'b1;
        end else if (state_q == ST_WB) begin
            reg_q   <= reg_q + 1'b1;
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        cmd_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_nt    = 1'b0;
        wb_valid      = 1'b0;
        done          = 1'b0;
        align_err     = 1'b0;
        mem_req_addr  = addr_q;
        wb_idx        = first_idx + IDX_W'(reg_q);
        unique case (state_q)
            ST_IDLE: cmd_ready = 1'b1;
            ST_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_nt    = 1'b1;
            end
            ST_WB:   wb_valid  = 1'b1;
            ST_DONE: done      = 1'b1;
            ST_ERR:  align_err = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/vlm_checker.sv
module vlm_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_sp,
    input logic [4:0]        cmd_rn,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_req_nt,
    input logic              wb_valid,
    input logic              done,
    input logic              align_err
);
    p_nt_on_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_nt);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    p_wb_not_with_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && mem_req_valid));

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    p_done_after_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wb_valid) && !cmd_ready));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_sp_misalign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_rn == 5'd31) && (cmd_sp[3:0] != 4'd0))
        |=> (align_err && !mem_req_valid && !wb_valid && !done));
endmodule

bind vec_multi_load_seq vlm_checker #(
    .ADDR_W (ADDR_W)
) u_vlm_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_sp        (cmd_sp),
    .cmd_rn        (cmd_rn),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_nt    (mem_req_nt),
    .wb_valid      (wb_valid),
    .done          (done),
    .align_err     (align_err)
);

// File: tb/vec_multi_load_seq_bench.sv
module vec_multi_load_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int VLEN       = 128;
    localparam int W          = VLEN / 32;
    localparam int WATCHDOG   = 190000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [63:0]  cmd_base = '0;
    logic [63:0]  cmd_sp = '0;
    logic [4:0]   cmd_rn = '0;
    logic [3:0]   cmd_imm = '0;
    logic         cmd_quad = 1'b0;
    logic [3:0]   cmd_zt = '0;
    logic [4:0]   cmd_count = '0;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [63:0]  mem_req_addr;
    logic         mem_req_nt;
    logic         mem_rsp_valid = 1'b0;
    logic [31:0]  mem_rsp_data = '0;
    logic         wb_valid;
    logic [4:0]   wb_idx;
    logic [VLEN-1:0] wb_data;
    logic         done;
    logic         align_err;

    vec_multi_load_seq #(.VLEN(VLEN)) u_vec_multi_load_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_base(cmd_base), .cmd_sp(cmd_sp), .cmd_rn(cmd_rn),
        .cmd_imm(cmd_imm), .cmd_quad(cmd_quad), .cmd_zt(cmd_zt),
        .cmd_count(cmd_count),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_nt(mem_req_nt),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
        .done(done), .align_err(align_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int n_req = 0;
    int n_wb = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    bit busy = 0;
    bit prev_done = 0;
    bit prev_wait = 0;
    logic [63:0] prev_addr = '0;
    bit pend = 0;
    int rdly = 0;
    logic [63:0] pend_addr = '0;
    logic [63:0] req_log [0:31];
    logic [4:0]  wbi_log [0:7];
    logic [VLEN-1:0] wbd_log [0:7];

    function automatic logic [31:0] memf(input logic [63:0] a);
        return (a[31:0] * 32'h9E37_79B1) ^ a[63:32] ^ 32'h1357_2468;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [VLEN-1:0] act,
                       input logic [VLEN-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Memory model and port monitor, all at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (mem_rsp_valid) mem_rsp_valid = 1'b0;
            if (pend) begin
                if (rdly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = memf(pend_addr);
                    pend = 0;
                end else begin
                    rdly--;
                end
            end
            if (wb_valid) begin
                if (n_wb < 8) begin
                    wbi_log[n_wb] = wb_idx;
                    wbd_log[n_wb] = wb_data;
                end
                n_wb++;
            end
            if (done) begin
                done_cnt++;
                busy = 0;
            end
            if (done && prev_done)
                chk(0, "R10 done longer than one cycle", VLEN'(1), VLEN'(0));
            prev_done = done;
            if (align_err) begin
                err_cnt++;
                busy = 0;
            end
            if (busy && cmd_ready)
                chk(0, "R10 cmd_ready high while busy", VLEN'(1), VLEN'(0));
            if (prev_wait)
                chk(mem_req_valid && (mem_req_addr == prev_addr), "R9 request held",
                    VLEN'({mem_req_valid, mem_req_addr}), VLEN'({1'b1, prev_addr}));
            mem_req_ready = ((cyc % 3) != 1);
            if (mem_req_valid)
                chk(mem_req_nt == 1'b1, "R8 hint on request", VLEN'(mem_req_nt), VLEN'(1));
            if (mem_req_valid && pend)
                chk(0, "R9 second read outstanding", VLEN'(1), VLEN'(0));
            prev_wait = mem_req_valid && !mem_req_ready;
            prev_addr = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                if (n_req < 32) req_log[n_req] = mem_req_addr;
                n_req++;
                pend = 1;
                pend_addr = mem_req_addr;
                rdly = cyc % 2;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        chk(0, "watchdog expired", VLEN'(0), VLEN'(1));
        finish_run();
    end

    task automatic run(input bit quad, input logic [3:0] zt, input logic [4:0] rn,
                       input logic [63:0] base, input logic [63:0] sp,
                       input logic [3:0] imm, input logic [4:0] count);
        int d0, e0, t, nreg, ereq;
        logic [63:0] b, start, ea;
        logic [VLEN-1:0] ev;
        logic [4:0] eidx;
        bit misal;
        @(negedge clk); #1;
        n_req = 0; n_wb = 0;
        d0 = done_cnt; e0 = err_cnt;
        cmd_valid = 1'b1; cmd_quad = quad; cmd_zt = zt; cmd_rn = rn;
        cmd_base = base; cmd_sp = sp; cmd_imm = imm; cmd_count = count;
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        busy = (done_cnt == d0) && (err_cnt == e0);
        t = 0;
        while ((done_cnt == d0) && (err_cnt == e0) && (t < 3000)) begin
            @(negedge clk); #1;
            t++;
        end
        nreg  = quad ? 4 : 2;
        misal = (rn == 5'd31) && (sp[3:0] != 4'd0);
        b     = (rn == 5'd31) ? sp : base;
        if (misal) begin
            chk(err_cnt == e0 + 1, "R7 align_err pulse", VLEN'(err_cnt - e0), VLEN'(1));
            chk(n_req == 0 && n_wb == 0 && done_cnt == d0, "R7 no activity on misaligned sp",
                VLEN'({n_req[7:0], n_wb[7:0], 8'(done_cnt - d0)}), VLEN'(0));
        end else begin
            chk(done_cnt == d0 + 1 && err_cnt == e0, "R10 done once",
                VLEN'(done_cnt - d0), VLEN'(1));
            start = b + ({{60{imm[3]}}, imm} * 64'(nreg * W * 4));
            ereq = 0;
            for (int i = 0; i < nreg * W; i++) begin
                if (i < count) begin
                    ea = start + 64'(4 * i);
                    if (ereq < n_req && ereq < 32)
                        chk(req_log[ereq] == ea, (ereq == 0) ? "R1 start address" : "R2 element address",
                            VLEN'(req_log[ereq]), VLEN'(ea));
                    ereq++;
                end
            end
            chk(n_req == ereq, "R3 read count", VLEN'(n_req), VLEN'(ereq));
            chk(n_wb == nreg, "R5 writeback count", VLEN'(n_wb), VLEN'(nreg));
            for (int r = 0; r < nreg && r < n_wb; r++) begin
                eidx = quad ? 5'({zt[2:0], 2'b00} + 5'(r)) : 5'({zt, 1'b0} + 5'(r));
                chk(wbi_log[r] == eidx, "R6 destination index", VLEN'(wbi_log[r]), VLEN'(eidx));
                ev = '0;
                for (int e = 0; e < W; e++) begin
                    if ((r * W + e) < count)
                        ev[32*e +: 32] = memf(start + 64'(4 * (r * W + e)));
                end
                chk(wbd_log[r] == ev, "R4 register data", wbd_log[r], ev);
            end
        end
    endtask

    initial begin
        int immv [4] = '{-8, -1, 0, 5};
        logic [63:0] bases [3] = '{64'h0000_1234_5678_9A00, 64'hFFFF_FFFF_FFFF_FFF0,
                                   64'h0000_0000_0000_0013};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(cmd_ready && !mem_req_valid && !wb_valid && !done && !align_err,
            "R10 reset state", VLEN'({cmd_ready, mem_req_valid, wb_valid, done, align_err}),
            VLEN'(5'b10000));
        for (int q = 0; q < 2; q++) begin
            for (int c = 0; c <= 18; c++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [4:0] cnt;
                    cnt = (c == 18) ? 5'd31 : 5'(c);
                    // general register base, cmd_sp misaligned but unused
                    run(q[0], 4'(c + k * 5), 5'(c % 31), bases[(c + k) % 3],
                        64'h0000_0000_0000_0007, 4'(immv[k]), cnt);
                    // stack-pointer base, aligned, cmd_base different
                    run(q[0], 4'(15 - c), 5'd31, 64'hDEAD_BEEF_0000_0004,
                        64'h0000_7FFF_FFFF_FF00 + 64'(c * 16), 4'(immv[k]), cnt);
                end
            end
        end
        for (int m = 1; m < 16; m += 3) begin
            run(m[0], 4'(m), 5'd31, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_2000 + 64'(m),
                4'(m), 5'd9);
        end
        // aligned sp after the errors
        run(1'b1, 4'd7, 5'd31, 64'h1, 64'h0000_0000_0000_4000, 4'd1, 5'd16);
        finish_run();
    end
endmodule